// File: doc/BRIEF.md
# Dual Video Stream Frame Aligner

This block takes two pixel streams in one clock domain and hands them on as a pair whose frames begin on the same cycle, ready for a serializer that carries both streams on one link. Each input pixel comes with a valid strobe and a start-of-frame flag. The phase between the two streams' frames is arbitrary, but both have the same frame length and advance together.

Stream A goes without pause into a circular frame store that is exactly one frame deep. The store keeps the start-of-frame flag next to each pixel, and the write address at which the newest A frame began is recorded. Stream B is watched for its start of frame. When that start arrives and an A frame start has already been recorded, readback begins at the recorded address. From then on every B pixel leaves paired with the A pixel at the same frame offset. Each later B frame start reloads the read address from the newest recorded A frame start.

Top module: `dual_frame_aligner`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid`, `out_a_sof` and `out_b_sof` are 0.
- R2: Until the first accepted B frame start, `out_valid` stays 0 whatever stream A carries.
- R3: A B frame start is accepted only if an A frame start was captured on an earlier cycle. A B start that comes before any A start, or on the same cycle as the first one, is ignored, and the block waits for the next B start.
- R4: The accepted B frame start leaves on `out_b_sof` one cycle later (latency 1 with `EXTRA_OUT_STAGE`=0), and `out_a_sof` is high on that same cycle. When `out_valid` is high the two flags are always equal.
- R5: Once locked, every input cycle with `b_valid`=1 gives, one cycle later, `out_valid`=1 with `out_b_data` equal to that `b_data`. A cycle with `b_valid`=0 gives `out_valid`=0.
- R6: The B pixel at frame offset k is paired on `out_a_data` with the A pixel at offset k of the newest A frame whose start came on a cycle before the accepted B start.
- R7: Cycles with the valids low (both streams stalled together) move no address, so the pairing survives stalls.
- R8: Write and read addresses wrap at `FRAME_LEN`. The pairing holds for every B lag from 1 up to `FRAME_LEN` pixels behind A, including a lag of a whole frame, where a location is read on the same cycle it is overwritten and the old pixel is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both streams |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Stream A pixel present |
| a_sof | input | 1 | Stream A first pixel of a frame |
| a_data | input | DATA_W | Stream A pixel |
| b_valid | input | 1 | Stream B pixel present |
| b_sof | input | 1 | Stream B first pixel of a frame |
| b_data | input | DATA_W | Stream B pixel |
| out_valid | output | 1 | Aligned pair present |
| out_a_sof | output | 1 | Frame start flag read back with the A pixel |
| out_b_sof | output | 1 | Frame start flag carried with the B pixel |
| out_a_data | output | DATA_W | Stream A pixel replayed from the store |
| out_b_data | output | DATA_W | Stream B pixel, live |

## Verification
The bench goes after the edges of the allowed lag. At a lag of one pixel, a store that writes late would return the previous frame. At a lag of `FRAME_LEN`-1, a store one entry short would return the next frame. At a lag of a whole frame, a write-first store would hand back the new pixel. A B start on the same cycle as the first A start, and one before any A start, must both be ignored; a design that takes them would lock with a bogus start address and emit valid output a frame early. Random shared stalls catch pointers that move on idle cycles, which shows up as A data shifted against B.

// File: rtl/dfa_pkg.sv
package dfa_pkg;
   typedef enum logic {
      AL_SEEK   = 1'b0,
      AL_LOCKED = 1'b1
   } align_state_e;

   function automatic int unsigned addr_bits(input int unsigned depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction
endpackage

// File: rtl/dfa_wr_track.sv
module dfa_wr_track #(
   parameter int unsigned FRAME_LEN = 64,
   parameter int unsigned AW        = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          a_valid,
   input  logic          a_sof,
   output logic [AW-1:0] wr_addr,
   output logic [AW-1:0] start_addr,
   output logic          a_armed
);
   localparam logic [AW-1:0] LAST = AW'(FRAME_LEN - 1);

   logic [AW-1:0] wptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr       <= '0;
         start_addr <= '0;
         a_armed    <= 1'b0;
      end else if (a_valid) begin
         wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
         if (a_sof) begin
            start_addr <= wptr;
            a_armed    <= 1'b1;
         end
      end
   end

   assign wr_addr = wptr;

   assert_wptr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wptr <= LAST);
   assert_wptr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (a_valid && wptr == LAST) |=> (wptr == '0));
   assert_wptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !a_valid |=> $stable(wptr));
endmodule

// File: rtl/dfa_frame_store.sv
module dfa_frame_store #(
   parameter int unsigned WIDTH = 17,
   parameter int unsigned DEPTH = 64,
   parameter int unsigned AW    = 6
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_word,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_word
);
   logic [WIDTH-1:0] mem [DEPTH];

   // Read-first: a read on the cycle its location is written returns the old word.
   always_ff @(posedge clk) begin
      rd_word <= mem[rd_addr];
      if (wr_en) mem[wr_addr] <= wr_word;
   end
endmodule

// File: rtl/dfa_rd_ctrl.sv
module dfa_rd_ctrl
   import dfa_pkg::*;
#(
   parameter int unsigned FRAME_LEN = 64,
   parameter int unsigned AW        = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          b_valid,
   input  logic          b_sof,
   input  logic          a_armed,
   input  logic [AW-1:0] a_start,
   output logic [AW-1:0] rd_addr,
   output logic          go,
   output logic          paired,
   output logic          locked
);
   localparam logic [AW-1:0] LAST = AW'(FRAME_LEN - 1);

   align_state_e  state;
   logic [AW-1:0] rptr;

   assign go      = b_valid && b_sof && a_armed;
   assign locked  = (state == AL_LOCKED);
   assign paired  = b_valid && (locked || go);
   assign rd_addr = go ? a_start : rptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= AL_SEEK;
         rptr  <= '0;
      end else begin
         if (go) state <= AL_LOCKED;
         if (paired) rptr <= (rd_addr == LAST) ? '0 : rd_addr + 1'b1;
      end
   end

   assert_early_b_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked && !a_armed) |=> !locked);
   assert_rptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !b_valid |=> $stable(rptr));
   assert_rptr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rptr <= LAST);
endmodule

// File: rtl/dual_frame_aligner.sv
module dual_frame_aligner
   import dfa_pkg::*;
#(
   parameter int unsigned DATA_W          = 16,
   parameter int unsigned FRAME_LEN       = 64,
   parameter bit          EXTRA_OUT_STAGE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_valid,
   input  logic              a_sof,
   input  logic [DATA_W-1:0] a_data,
   input  logic              b_valid,
   input  logic              b_sof,
   input  logic [DATA_W-1:0] b_data,
   output logic              out_valid,
   output logic              out_a_sof,
   output logic              out_b_sof,
   output logic [DATA_W-1:0] out_a_data,
   output logic [DATA_W-1:0] out_b_data
);
   localparam int unsigned AW = addr_bits(FRAME_LEN);
   localparam int unsigned WW = DATA_W + 1;

   if (FRAME_LEN < 2) begin : g_bad_frame
      $error("FRAME_LEN must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end

   logic [AW-1:0] wr_addr, start_addr, rd_addr;
   logic          a_armed, go, paired, locked;
   logic [WW-1:0] rd_word;

   dfa_wr_track #(.FRAME_LEN(FRAME_LEN), .AW(AW)) u_wr (
      .clk(clk), .rst_n(rst_n), .a_valid(a_valid), .a_sof(a_sof),
      .wr_addr(wr_addr), .start_addr(start_addr), .a_armed(a_armed)
   );

   dfa_frame_store #(.WIDTH(WW), .DEPTH(FRAME_LEN), .AW(AW)) u_store (
      .clk(clk), .wr_en(a_valid), .wr_addr(wr_addr),
      .wr_word({a_sof, a_data}), .rd_addr(rd_addr), .rd_word(rd_word)
   );

   dfa_rd_ctrl #(.FRAME_LEN(FRAME_LEN), .AW(AW)) u_rd (
      .clk(clk), .rst_n(rst_n), .b_valid(b_valid), .b_sof(b_sof),
      .a_armed(a_armed), .a_start(start_addr), .rd_addr(rd_addr),
      .go(go), .paired(paired), .locked(locked)
   );

   // First stage lines up live B with the registered store read.
   logic              s1_valid, s1_b_sof;
   logic [DATA_W-1:0] s1_b_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         s1_b_sof  <= 1'b0;
         s1_b_data <= '0;
      end else begin
         s1_valid  <= paired;
         s1_b_sof  <= go;
         s1_b_data <= b_data;
      end
   end

   logic              s1_a_sof;
   logic [DATA_W-1:0] s1_a_data;
   assign s1_a_sof  = rd_word[DATA_W] && s1_valid;
   assign s1_a_data = rd_word[DATA_W-1:0];

   if (EXTRA_OUT_STAGE) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid  <= 1'b0;
            out_a_sof  <= 1'b0;
            out_b_sof  <= 1'b0;
            out_a_data <= '0;
            out_b_data <= '0;
         end else begin
            out_valid  <= s1_valid;
            out_a_sof  <= s1_a_sof;
            out_b_sof  <= s1_b_sof;
            out_a_data <= s1_a_data;
            out_b_data <= s1_b_data;
         end
      end
   end else begin : g_out_direct
      assign out_valid  = s1_valid;
      assign out_a_sof  = s1_a_sof;
      assign out_b_sof  = s1_b_sof;
      assign out_a_data = s1_a_data;
      assign out_b_data = s1_b_data;
   end

   assert_sof_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_a_sof == out_b_sof));
   assert_no_valid_unlocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> locked);
   assert_sof_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_b_sof |-> out_valid);
endmodule

// File: tb/dual_frame_aligner_bench.sv
module dual_frame_aligner_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int FL = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          a_valid = 1'b0, a_sof = 1'b0, b_valid = 1'b0, b_sof = 1'b0;
   logic [DW-1:0] a_data = '0, b_data = '0;
   logic          out_valid, out_a_sof, out_b_sof;
   logic [DW-1:0] out_a_data, out_b_data;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_frame_aligner #(.DATA_W(DW), .FRAME_LEN(FL)) u_dual_frame_aligner (
      .clk(clk), .rst_n(rst_n),
      .a_valid(a_valid), .a_sof(a_sof), .a_data(a_data),
      .b_valid(b_valid), .b_sof(b_sof), .b_data(b_data),
      .out_valid(out_valid), .out_a_sof(out_a_sof), .out_b_sof(out_b_sof),
      .out_a_data(out_a_data), .out_b_data(out_b_data)
   );

   logic [DW-1:0] salt [16];

   function automatic logic [DW-1:0] a_pix(input int fr, input int off);
      return DW'(salt[fr & 15] + DW'(off * 97));
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Model state and pending expectation (latency 1)
   bit            m_armed, m_locked;
   int            m_latest, m_cur;
   bit            p_valid, p_sof;
   logic [DW-1:0] p_a, p_b;
   bit            p_stall;

   task automatic run_scenario(input int sa, input int sb, input int stall_pct,
                               input string tag);
      int step = 0;
      for (int f = 0; f < 16; f++) salt[f] = DW'($urandom);
      @(negedge clk);
      rst_n = 1'b0; a_valid = 0; b_valid = 0; a_sof = 0; b_sof = 0;
      repeat (3) @(negedge clk);
      check(out_valid === 1'b0 && out_a_sof === 1'b0 && out_b_sof === 1'b0,
            "R1", "reset outputs", {out_valid, out_a_sof, out_b_sof}, '0);
      rst_n = 1'b1;
      m_armed = 0; m_locked = 0; m_latest = 0; m_cur = 0;
      p_valid = 0; p_sof = 0; p_a = '0; p_b = '0; p_stall = 0;
      for (int cyc = 0; cyc < 4 * FL + 40; cyc++) begin
         @(negedge clk);
         // check what the previous drive cycle produced
         begin
            string vt;
            vt = p_stall ? "R7" : (m_locked ? "R5" : (cyc < 2 ? "R1" : "R2 R3"));
            check(out_valid === p_valid, vt, "out_valid", DW'(out_valid), DW'(p_valid));
            if (p_valid) begin
               check(out_b_sof === p_sof && out_a_sof === p_sof, "R4", "sof pair",
                     DW'({out_a_sof, out_b_sof}), DW'({p_sof, p_sof}));
               check(out_b_data === p_b, "R5", "b data", out_b_data, p_b);
               check(out_a_data === p_a, tag, "a data", out_a_data, p_a);
            end
         end
         // drive next cycle
         begin
            bit adv;
            int ia, ib, oa, ob;
            bit asof_n, bsof_n, go;
            logic [DW-1:0] bd;
            adv = (($urandom % 100) >= stall_pct);
            ia = step - sa; ib = step - sb;
            oa = (ia >= 0) ? ia % FL : 0;
            ob = (ib >= 0) ? ib % FL : 0;
            asof_n = (ia >= 0) && (oa == 0);
            bsof_n = (ib >= 0) && (ob == 0);
            bd = DW'($urandom);
            a_valid = adv; b_valid = adv;
            a_sof = asof_n; b_sof = bsof_n;
            a_data = (ia >= 0) ? a_pix(ia / FL, oa) : DW'($urandom);
            b_data = bd;
            p_stall = !adv && m_locked;
            if (adv) begin
               go = bsof_n && m_armed;
               if (go) begin m_locked = 1; m_cur = m_latest; end
               p_valid = m_locked;
               p_sof = go;
               p_a = a_pix(m_cur, ob);
               p_b = bd;
               if (asof_n) begin m_latest = ia / FL; m_armed = 1; end
               step++;
            end else begin
               p_valid = 0; p_sof = 0;
            end
         end
      end
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (2) @(negedge clk);
      run_scenario(3, 4, 0, "R6");              // lag of one pixel
      run_scenario(3, 3 + FL - 1, 0, "R8");     // lag of FRAME_LEN-1
      run_scenario(5, 5, 0, "R3 R8");           // same-cycle start, lag of a whole frame
      run_scenario(12, 2, 0, "R3");             // B starts before A
      for (int r = 0; r < 6; r++) begin
         int sa;
         sa = 1 + int'($urandom % 8);
         run_scenario(sa, sa + 1 + int'($urandom % (FL - 1)), 25, "R6 R7");
      end
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule